// File: doc/BRIEF.md
# Instruction length and cycle calculator

This block inspects the first 16-bit word of an instruction for a compact processor with sixteen registers. It tells a fetch unit or an issue scheduler two things before any operand is read: how many words the instruction occupies, and how many clock cycles it will take. It also reports which of the three encoding formats the word belongs to, and whether the word fits none of them.

The cycle figure is a sum of per-access costs. The instruction fetch costs one cycle. The source and destination addressing modes each add their own cost. A result written back to memory adds one cycle, and a write into the program counter adds one cycle. Two registers double as constant generators: a source that selects one of them costs nothing and needs no extension word. Jumps always take one word and two cycles. Single-operand words are tagged but not timed. The block does not fetch extension words and executes nothing.

A parameter selects the output stage. The outputs can be combinational, or they can be registered and then loaded one clock after a valid strobe and held until the next one.

Top module: `instr_cost_calc`

## Requirements
- R1: The format code is taken from the top bits of the word. Opcode nibble [15:12] of 4 to 15 gives two-operand, code 0. Bits [15:13]=001 give jump, code 2. Bits [15:10]=000100 give single-operand, code 1. Any other word gives code 3 with the illegal flag set. The illegal flag is 0 for the other three formats.
- R2: A jump word reports 1 word and 2 cycles.
- R3: The two-operand fields are: source register [11:8], destination mode bit [7], size bit [6], source mode [5:4], destination register [3:0]. With register-mode source and register-mode destination (destination not register 0), the cost is 1 word and 1 cycle. Example: 0x540A.
- R4: A source in indirect mode (10) or in auto-increment mode (11) with a source register other than 0 adds 1 cycle and no word. Example: 0x542A gives 1 word and 2 cycles.
- R5: A source in indexed mode (01) adds 2 cycles and 1 word. This holds for any register except register 3, so the absolute (register 2) and PC-relative (register 0) forms are included. Example: 0x541A gives 2 words and 3 cycles.
- R6: An immediate source (source mode 11 with register 0) adds 1 cycle and 1 word. Example: 0x503A gives 2 words and 2 cycles.
- R7: Constant-generator sources add no cycle and no word. These are register 3 with any source mode, and register 2 with source mode 10 or 11. Example: 0x531A gives 1 word and 1 cycle.
- R8: An indexed destination (bit [7]=1) adds 2 cycles and 1 word. When the opcode writes its result, it adds 1 more cycle for the memory write-back. Opcodes 9 (compare) and 11 (bit test) do not write. Examples: 0x5090 gives 3 words and 6 cycles; 0x9090 gives 3 words and 5 cycles.
- R9: A register-mode destination of register 0 (the program counter) adds 1 cycle, except for opcodes 9 and 11. Example: 0x4400 gives 2 cycles; 0x9400 gives 1 cycle.
- R10: Single-operand and illegal words report 0 words and 0 cycles.
- R11: With REGISTERED=1, reset sets the outputs to 0 words, 0 cycles, format code 3 and illegal 0. The outputs take the result for a word one clock after the edge at which valid is sampled high, and they hold their value while valid is low, whatever the instruction input does.
- R12: With REGISTERED=0, the outputs show the result for the current word in the same cycle while valid is high. While valid is low they show 0 words, 0 cycles, code 3 and illegal 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered output stage |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the instruction word as valid |
| instr | input | 16 | First word of the instruction |
| len_words | output | 2 | Instruction length in words |
| cycles | output | 3 | Execution time in clock cycles |
| fmt | output | 2 | Format code: 0 two-operand, 1 single-operand, 2 jump, 3 none |
| illegal | output | 1 | Word matches no format |

## Verification
The bench builds two instances side by side from the same stimulus: one with REGISTERED=1 and one with REGISTERED=0. Every vector is therefore checked in the cycle it is driven, through the combinational path, and one edge later, through the register. The registered instance alone exposes reset values and holding while valid is low. The combinational instance alone exposes the idle values shown while valid is low.

// File: rtl/instr_cost_pkg.sv
package instr_cost_pkg;

    parameter int INSTR_W = 16;
    parameter int REG_W   = 4;
    parameter int LEN_W   = 2;
    parameter int CYC_W   = 3;

    localparam logic [REG_W-1:0] PC_REG  = REG_W'(0);
    localparam logic [REG_W-1:0] CG_LO   = REG_W'(2);
    localparam logic [REG_W-1:0] CG_HI   = REG_W'(3);
    localparam logic [3:0]       OP_CMP  = 4'h9;
    localparam logic [3:0]       OP_BIT  = 4'hB;

    typedef enum logic [1:0] {
        FMT_DUAL   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_JUMP   = 2'd2,
        FMT_NONE   = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        SM_REG   = 2'b00,
        SM_INDEX = 2'b01,
        SM_IND   = 2'b10,
        SM_AUTO  = 2'b11
    } src_mode_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [CYC_W-1:0] cyc;
        fmt_e             fmt;
        logic             bad;
    } cost_info_t;

    localparam cost_info_t IDLE_INFO = '{len: '0, cyc: '0, fmt: FMT_NONE, bad: 1'b0};

    function automatic logic is_const_src(input logic [REG_W-1:0] r, input src_mode_e m);
        return (r == CG_HI) || ((r == CG_LO) && (m == SM_IND || m == SM_AUTO));
    endfunction

    function automatic logic op_stores(input logic [3:0] op);
        return (op != OP_CMP) && (op != OP_BIT);
    endfunction

endpackage

// File: rtl/instr_fmt_classify.sv
module instr_fmt_classify
    import instr_cost_pkg::*;
(
    input  logic [INSTR_W-1:0] word_i,
    output fmt_e               fmt_o,
    output logic               bad_o
);
    always_comb begin
        if (word_i[15:12] >= 4'd4)
            fmt_o = FMT_DUAL;
        else if (word_i[15:13] == 3'b001)
            fmt_o = FMT_JUMP;
        else if (word_i[15:10] == 6'b000100)
            fmt_o = FMT_SINGLE;
        else
            fmt_o = FMT_NONE;
        bad_o = (fmt_o == FMT_NONE);
    end
endmodule

// File: rtl/instr_dual_cost.sv
module instr_dual_cost
    import instr_cost_pkg::*;
(
    input  logic [INSTR_W-1:0] word_i,
    output logic [LEN_W-1:0]   len_o,
    output logic [CYC_W-1:0]   cyc_o
);
    logic [3:0]       op;
    logic [REG_W-1:0] sreg;
    logic [REG_W-1:0] dreg;
    logic             dst_idx;
    src_mode_e        smode;
    logic             stores;

    assign op      = word_i[15:12];
    assign sreg    = word_i[11:8];
    assign dst_idx = word_i[7];
    assign smode   = src_mode_e'(word_i[5:4]);
    assign dreg    = word_i[3:0];
    assign stores  = op_stores(op);

    always_comb begin
        len_o = LEN_W'(1);
        cyc_o = CYC_W'(1);
        if (!is_const_src(sreg, smode)) begin
            unique case (smode)
                SM_INDEX: begin
                    cyc_o = cyc_o + CYC_W'(2);
                    len_o = len_o + LEN_W'(1);
                end
                SM_IND:   cyc_o = cyc_o + CYC_W'(1);
                SM_AUTO: begin
                    cyc_o = cyc_o + CYC_W'(1);
                    if (sreg == PC_REG)
                        len_o = len_o + LEN_W'(1);
                end
                default: ;
            endcase
        end
        if (dst_idx) begin
            cyc_o = cyc_o + CYC_W'(2);
            len_o = len_o + LEN_W'(1);
            if (stores)
                cyc_o = cyc_o + CYC_W'(1);
        end else if (dreg == PC_REG && stores) begin
            cyc_o = cyc_o + CYC_W'(1);
        end
    end
endmodule

// File: rtl/instr_cost_merge.sv
module instr_cost_merge
    import instr_cost_pkg::*;
(
    input  logic             valid_i,
    input  fmt_e             fmt_i,
    input  logic             bad_i,
    input  logic [LEN_W-1:0] dual_len_i,
    input  logic [CYC_W-1:0] dual_cyc_i,
    output cost_info_t       info_o
);
    always_comb begin
        info_o     = IDLE_INFO;
        info_o.fmt = fmt_i;
        info_o.bad = bad_i;
        unique case (fmt_i)
            FMT_DUAL: begin
                info_o.len = dual_len_i;
                info_o.cyc = dual_cyc_i;
            end
            FMT_JUMP: begin
                info_o.len = LEN_W'(1);
                info_o.cyc = CYC_W'(2);
            end
            default: ;
        endcase
        if (!valid_i)
            info_o = IDLE_INFO;
    end
endmodule

// File: rtl/instr_cost_calc.sv
module instr_cost_calc
    import instr_cost_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    output logic [LEN_W-1:0]   len_words,
    output logic [CYC_W-1:0]   cycles,
    output logic [1:0]         fmt,
    output logic               illegal
);
    fmt_e             fmt_c;
    logic             bad_c;
    logic [LEN_W-1:0] dual_len;
    logic [CYC_W-1:0] dual_cyc;
    cost_info_t       info_n;
    cost_info_t       info_out;

    instr_fmt_classify u_class (
        .word_i (instr),
        .fmt_o  (fmt_c),
        .bad_o  (bad_c)
    );

    instr_dual_cost u_dual (
        .word_i (instr),
        .len_o  (dual_len),
        .cyc_o  (dual_cyc)
    );

    instr_cost_merge u_merge (
        .valid_i    (in_valid),
        .fmt_i      (fmt_c),
        .bad_i      (bad_c),
        .dual_len_i (dual_len),
        .dual_cyc_i (dual_cyc),
        .info_o     (info_n)
    );

    generate
        if (REGISTERED) begin : g_reg
            cost_info_t info_q;
            always_ff @(posedge clk) begin
                if (rst)
                    info_q <= IDLE_INFO;
                else if (in_valid)
                    info_q <= info_n;
            end
            assign info_out = info_q;

            a_r11_hold: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> $stable(info_q));
            a_r2_jump_cost: assert property (@(posedge clk) disable iff (rst)
                (in_valid && instr[15:13] == 3'b001) |=>
                    (len_words == LEN_W'(1) && cycles == CYC_W'(2) && fmt == 2'd2));
            a_r8_dst_index_len: assert property (@(posedge clk) disable iff (rst)
                (in_valid && instr[15:12] >= 4'd4 && instr[7]) |=>
                    (len_words >= LEN_W'(2) && cycles >= CYC_W'(3)));
        end else begin : g_comb
            assign info_out = info_n;

            a_r12_idle: assert property (@(posedge clk) disable iff (rst)
                !in_valid |-> (len_words == '0 && cycles == '0 && fmt == 2'd3 && !illegal));
        end
    endgenerate

    assign len_words = info_out.len;
    assign cycles    = info_out.cyc;
    assign fmt       = info_out.fmt;
    assign illegal   = info_out.bad;

    a_r10_empty_when_untimed: assert property (@(posedge clk) disable iff (rst)
        (illegal || fmt == 2'd1) |-> (len_words == '0 && cycles == '0));
    a_r1_illegal_code: assert property (@(posedge clk) disable iff (rst)
        illegal |-> fmt == 2'd3);
    a_r3_cycles_cover_words: assert property (@(posedge clk) disable iff (rst)
        fmt == 2'd0 |-> (CYC_W'(len_words) <= cycles && len_words != '0));
endmodule

// File: tb/instr_cost_calc_test.sv
module instr_cost_calc_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [1:0]  r_len, c_len;
    logic [2:0]  r_cyc, c_cyc;
    logic [1:0]  r_fmt, c_fmt;
    logic        r_ill, c_ill;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    instr_cost_calc #(.REGISTERED(1'b1)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .len_words(r_len), .cycles(r_cyc), .fmt(r_fmt), .illegal(r_ill)
    );

    instr_cost_calc #(.REGISTERED(1'b0)) uut_comb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .len_words(c_len), .cycles(c_cyc), .fmt(c_fmt), .illegal(c_ill)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic chk_set(input string req, input string tag,
                           input logic [1:0] l, input logic [2:0] c,
                           input logic [1:0] f, input logic i,
                           input int el, input int ec, input int ef, input int ei);
        chk(req, {tag, " len"}, l, el);
        chk(req, {tag, " cyc"}, c, ec);
        chk(req, {tag, " fmt"}, f, ef);
        chk(req, {tag, " ill"}, i, ei);
    endtask

    // Drives one valid word, checks the combinational instance in that cycle (R12)
    // and the registered instance one edge later (R11).
    task automatic apply(input string req, input logic [15:0] w,
                         input int el, input int ec, input int ef, input int ei);
        @(negedge clk);
        instr = w;
        in_valid = 1'b1;
        #1;
        chk_set(req, $sformatf("comb %h", w), c_len, c_cyc, c_fmt, c_ill, el, ec, ef, ei);
        @(negedge clk);
        in_valid = 1'b0;
        chk_set(req, $sformatf("reg %h", w), r_len, r_cyc, r_fmt, r_ill, el, ec, ef, ei);
    endtask

    task automatic test_reset;
        chk_set("R11", "reset", r_len, r_cyc, r_fmt, r_ill, 0, 0, 3, 0);
    endtask

    task automatic test_formats;
        apply("R1", 16'h1000, 0, 0, 1, 0);
        apply("R1", 16'h13FF, 0, 0, 1, 0);
        apply("R1", 16'h0000, 0, 0, 3, 1);
        apply("R1", 16'h1400, 0, 0, 3, 1);
        apply("R10", 16'h0FFF, 0, 0, 3, 1);
    endtask

    task automatic test_jumps;
        apply("R2", 16'h2000, 1, 2, 2, 0);
        apply("R2", 16'h3FFF, 1, 2, 2, 0);
    endtask

    task automatic test_source_modes;
        apply("R3", 16'h540A, 1, 1, 0, 0);
        apply("R4", 16'h542A, 1, 2, 0, 0);
        apply("R4", 16'h543A, 1, 2, 0, 0);
        apply("R5", 16'h541A, 2, 3, 0, 0);
        apply("R5", 16'h521A, 2, 3, 0, 0);
        apply("R5", 16'h501A, 2, 3, 0, 0);
        apply("R6", 16'h503A, 2, 2, 0, 0);
    endtask

    task automatic test_constants;
        apply("R7", 16'h531A, 1, 1, 0, 0);
        apply("R7", 16'h532A, 1, 1, 0, 0);
        apply("R7", 16'h533A, 1, 1, 0, 0);
        apply("R7", 16'h522A, 1, 1, 0, 0);
        apply("R7", 16'h523A, 1, 1, 0, 0);
    endtask

    task automatic test_destinations;
        apply("R8", 16'h5090, 3, 6, 0, 0);
        apply("R8", 16'h9090, 3, 5, 0, 0);
        apply("R8", 16'hB090, 3, 5, 0, 0);
        apply("R8", 16'h4485, 2, 4, 0, 0);
        apply("R9", 16'h4400, 1, 2, 0, 0);
        apply("R9", 16'h9400, 1, 1, 0, 0);
        apply("R9", 16'h4030, 2, 3, 0, 0);
        apply("R9", 16'h9030, 2, 2, 0, 0);
    endtask

    task automatic test_hold;
        apply("R11", 16'h5090, 3, 6, 0, 0);
        @(negedge clk);
        instr = 16'h0000;
        #1;
        chk_set("R12", "comb idle", c_len, c_cyc, c_fmt, c_ill, 0, 0, 3, 0);
        repeat (3) @(negedge clk);
        instr = 16'h2000;
        @(negedge clk);
        chk_set("R11", "reg hold", r_len, r_cyc, r_fmt, r_ill, 3, 6, 0, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_formats();
        test_jumps();
        test_source_modes();
        test_constants();
        test_destinations();
        test_hold();
        finish_run();
    end

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end
endmodule